// File: doc/BRIEF.md
# Acquisition Delay Conversion Sequencer

This block times the acquisition window that follows a write to a converter's control register. A serial write is framed by an active-low frame strobe and clocked by a serial clock. Both signals are brought into the system clock domain through flop chains. The falling edge of the frame strobe raises a busy output. That output stays high until the sixth serial-clock falling edge of the frame has been seen. From then on it is held for a programmable number of system clock cycles. The default delay covers a 2 µs track/hold acquisition at 100 MHz.

A software conversion request is held pending while busy is high. It is released as a single-cycle conversion-start strobe once the window closes. A hardware start input is not held back by the window: its rising edge produces a strobe on the next clock edge whether or not busy is high. A write frame that begins while a window is still open keeps busy high and restarts the edge count.

Top module: `acq_conv_seq`

## Requirements
- R1: After reset is released, `acq_busy_o` and `conv_start_o` are low. They stay low until a frame or a start input arrives.
- R2: A falling edge on `frame_ni` makes `acq_busy_o` high at the third rising clock edge after the input change (SYNC_STAGES+1 edges).
- R3: While the frame is open, `acq_busy_o` stays high until the sixth `sclk_i` falling edge that occurs while `frame_ni` is low. Falling edges of `sclk_i` while `frame_ni` is high are not counted. Closing a frame early leaves `acq_busy_o` high.
- R4: Counting from the sixth qualifying `sclk_i` fall, `acq_busy_o` goes low at rising edge number SYNC_STAGES+1+DELAY_CYCLES after the input change. Further `sclk_i` edges in the same frame have no effect.
- R5: With DELAY_CYCLES = 0, `acq_busy_o` goes low at the same edge that registers the sixth fall, which is edge SYNC_STAGES+1.
- R6: A `sw_req_i` pulse seen while `acq_busy_o` is high produces no strobe while busy is high. It produces exactly one `conv_start_o` pulse at the edge after `acq_busy_o` falls.
- R7: A `sw_req_i` pulse seen while `acq_busy_o` is low produces a `conv_start_o` pulse at that same clock edge.
- R8: A rising edge on `hw_start_i` produces a one-cycle `conv_start_o` pulse at that clock edge, even while `acq_busy_o` is high. It does not change `acq_busy_o`.
- R9: A hardware start and a pending software start that fall in the same cycle yield one single-cycle strobe. The pending software request is consumed.
- R10: A `frame_ni` falling edge during an open window keeps `acq_busy_o` high and restarts the edge count. Six new qualifying falls are needed before the delay starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock of the write, asynchronous |
| frame_ni | input | 1 | Write frame strobe, active low, asynchronous |
| hw_start_i | input | 1 | Hardware conversion start, rising edge active, system domain |
| sw_req_i | input | 1 | Software conversion start request, one-cycle pulse, system domain |
| acq_busy_o | output | 1 | Acquisition window active |
| conv_start_o | output | 1 | One-cycle conversion start strobe |

## Verification
The hardware start path and the release of a pending software request can land in the same clock cycle. To provoke this, the bench queues a software request during a window. It measures the edge at which busy falls and raises `hw_start_i` in the cycle where the pending request is released. It judges the result by sampling `conv_start_o` over the following cycles and by counting strobes with an edge-sampled monitor. Exactly one pulse must appear, and no second strobe may follow later.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_TIMING = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= RST_VAL;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/acq_pulse_ctrl.sv
module acq_pulse_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned EDGE_IDX     = 6,
  parameter int unsigned DELAY_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic frame_low_i,
  input  logic sclk_fall_i,
  output logic busy_o
);
  localparam int unsigned EW = $clog2(EDGE_IDX + 1);
  localparam int unsigned DW = (DELAY_CYCLES < 1) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_IDX - 1);
  localparam logic [DW-1:0] DLY_LOAD  = DW'(DELAY_CYCLES);

  acq_state_e    state_q;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] dly_q;
  logic          edge_hit;

  assign edge_hit = (state_q == ST_ARMED) && sclk_fall_i && frame_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      dly_q   <= '0;
    end else if (frame_start_i) begin
      state_q <= ST_ARMED;
      edge_q  <= '0;
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (edge_hit) begin
            if (edge_q == EDGE_LAST) begin
              edge_q <= '0;
              if (DELAY_CYCLES == 0) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_TIMING;
                dly_q   <= DLY_LOAD;
              end
            end else begin
              edge_q <= edge_q + 1'b1;
            end
          end
        end
        ST_TIMING: begin
          if (dly_q == DW'(1)) state_q <= ST_IDLE;
          dly_q <= dly_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_busy_from_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_start_i));

  assert_edge_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED) |-> (edge_q <= EDGE_LAST));

  assert_dly_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TIMING) |-> (dly_q != '0 && dly_q <= DLY_LOAD));

  assert_fall_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(state_q == ST_TIMING) || $past(edge_hit)));

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (busy_o && edge_q == '0));
endmodule

// File: rtl/acq_start_arb.sv
module acq_start_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic hw_start_i,
  input  logic sw_req_i,
  output logic conv_start_o
);
  logic hw_q, pend_q, conv_q;
  logic hw_fire, want_sw, fire_sw;

  assign hw_fire = hw_start_i & ~hw_q;
  assign want_sw = pend_q | sw_req_i;
  assign fire_sw = want_sw & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q   <= 1'b0;
      pend_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      hw_q   <= hw_start_i;
      pend_q <= want_sw & ~fire_sw;
      conv_q <= hw_fire | fire_sw;
    end
  end

  assign conv_start_o = conv_q;

  assert_sw_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !hw_fire) |=> !conv_start_o);

  assert_sw_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !busy_i) |=> (conv_start_o && !pend_q));

  assert_hw_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hw_start_i) |=> conv_start_o);

  assert_merge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_fire && pend_q && !busy_i) |=> (conv_start_o && !pend_q));
endmodule

// File: rtl/acq_conv_seq.sv
module acq_conv_seq #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned EDGE_IDX     = 6,
  parameter int unsigned DELAY_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic frame_ni,
  input  logic hw_start_i,
  input  logic sw_req_i,
  output logic acq_busy_o,
  output logic conv_start_o
);
  logic sclk_s, sclk_rise, sclk_fall;
  logic frame_s, frame_rise, frame_fall;
  logic busy;

  acq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sclk_i),
    .q_o   (sclk_s),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  acq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_frame_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (frame_ni),
    .q_o   (frame_s),
    .rise_o(frame_rise),
    .fall_o(frame_fall)
  );

  acq_pulse_ctrl #(.EDGE_IDX(EDGE_IDX), .DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_fall),
    .frame_low_i  (~frame_s),
    .sclk_fall_i  (sclk_fall),
    .busy_o       (busy)
  );

  acq_start_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .hw_start_i  (hw_start_i),
    .sw_req_i    (sw_req_i),
    .conv_start_o(conv_start_o)
  );

  assign acq_busy_o = busy;

  assert_no_early_sclk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_s && !frame_fall && busy) |=> acq_busy_o || !$past(sclk_fall));

  assert_unused_edges_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise || frame_rise) |-> !(sclk_fall || frame_fall));
endmodule

// File: tb/tb_acq_conv_seq.sv
module tb_acq_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 200;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, frame_n = 1'b1, hw = 1'b0, sw = 1'b0;
  logic busy, conv, busy0, conv0;
  int total = 0, bad = 0, conv_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_conv_seq #(.SYNC_STAGES(SYNC), .EDGE_IDX(6), .DELAY_CYCLES(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_ni(frame_n),
    .hw_start_i(hw), .sw_req_i(sw), .acq_busy_o(busy), .conv_start_o(conv));

  acq_conv_seq #(.SYNC_STAGES(SYNC), .EDGE_IDX(6), .DELAY_CYCLES(0)) dut_zero (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_ni(frame_n),
    .hw_start_i(1'b0), .sw_req_i(1'b0), .acq_busy_o(busy0), .conv_start_o(conv0));

  always @(negedge clk) if (rst_n && conv) conv_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sclk_falls(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic open_frame();
    @(negedge clk) frame_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk) sclk = 1'b1; frame_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // drive the sixth fall, count rising edges until busy of dut (or dut_zero) drops
  task automatic sixth_and_measure(input bit zero, output int n);
    @(negedge clk) sclk = 1'b0;
    n = 0;
    for (int k = 0; k < DLY + 20; k++) begin
      @(posedge clk); #1;
      n++;
      if (!(zero ? busy0 : busy)) break;
    end
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(conv == 1'b0, "R1 conv", conv, 0);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && conv_cnt == 0, "R1 idle hold", conv_cnt, 0);
  endtask

  task automatic t_frame_rise();
    @(negedge clk) frame_n = 1'b0;
    @(posedge clk); #1; check(busy == 1'b0, "R2 edge1", busy, 0);
    @(posedge clk); #1; check(busy == 1'b0, "R2 edge2", busy, 0);
    @(posedge clk); #1; check(busy == 1'b1, "R2 edge3", busy, 1);
  endtask

  task automatic t_main_sw_pending();
    int n, c0;
    sclk_falls(5);
    repeat (DLY + 20) @(negedge clk);
    check(busy == 1'b1, "R3 five falls hold", busy, 1);
    @(negedge clk) sw = 1'b1;
    @(negedge clk) sw = 1'b0;
    c0 = conv_cnt;
    sixth_and_measure(1'b0, n);
    check(n == LAT + DLY, "R4 window length", n, LAT + DLY);
    check(conv_cnt == c0, "R6 no strobe while busy", conv_cnt - c0, 0);
    @(posedge clk); #1; check(conv == 1'b1, "R6 release strobe", conv, 1);
    @(posedge clk); #1; check(conv == 1'b0, "R6 single cycle", conv, 0);
    sclk_falls(2);
    check(busy == 1'b0, "R4 extra falls ignored", busy, 0);
    close_frame();
    check(conv_cnt == c0 + 1, "R6 one strobe", conv_cnt - c0, 1);
  endtask

  task automatic t_sw_idle();
    @(negedge clk) sw = 1'b1;
    @(posedge clk); #1; check(conv == 1'b1, "R7 idle strobe", conv, 1);
    @(negedge clk) sw = 1'b0;
    @(posedge clk); #1; check(conv == 1'b0, "R7 single", conv, 0);
  endtask

  task automatic t_hw_busy();
    int c0;
    open_frame();
    c0 = conv_cnt;
    @(negedge clk) hw = 1'b1;
    @(posedge clk); #1;
    check(conv == 1'b1, "R8 hw strobe", conv, 1);
    check(busy == 1'b1, "R8 busy kept", busy, 1);
    @(posedge clk); #1; check(conv == 1'b0, "R8 one cycle", conv, 0);
    repeat (10) @(negedge clk);
    hw = 1'b0;
    check(conv_cnt == c0 + 1 && busy == 1'b1, "R8 count", conv_cnt - c0, 1);
  endtask

  task automatic t_zero_delay();
    int n;
    sclk_falls(5);
    sixth_and_measure(1'b1, n);
    check(n == LAT, "R5 zero delay", n, LAT);
    check(busy == 1'b1, "R5 main still busy", busy, 1);
    repeat (DLY + 10) @(negedge clk);
    close_frame();
  endtask

  task automatic t_partial_frame();
    int n;
    open_frame();
    sclk_falls(3);
    close_frame();
    sclk_falls(5);
    repeat (DLY + 20) @(negedge clk);
    check(busy == 1'b1, "R3 early close and framed-out falls", busy, 1);
    open_frame();
    sclk_falls(5);
    sixth_and_measure(1'b0, n);
    check(n == LAT + DLY, "R3 fresh frame", n, LAT + DLY);
    close_frame();
  endtask

  task automatic t_restart();
    int n;
    open_frame();
    sclk_falls(6);
    repeat (50) @(negedge clk);
    close_frame();
    open_frame();
    sclk_falls(5);
    repeat (160) @(negedge clk);
    check(busy == 1'b1, "R10 restart holds", busy, 1);
    sixth_and_measure(1'b0, n);
    check(n == LAT + DLY, "R10 recount", n, LAT + DLY);
    close_frame();
  endtask

  task automatic t_coincide();
    int n, c0;
    open_frame();
    sclk_falls(5);
    @(negedge clk) sw = 1'b1;
    @(negedge clk) sw = 1'b0;
    c0 = conv_cnt;
    sixth_and_measure(1'b0, n);
    check(n == LAT + DLY, "R9 window", n, LAT + DLY);
    @(negedge clk) hw = 1'b1;
    @(posedge clk); #1; check(conv == 1'b1, "R9 merged strobe", conv, 1);
    @(posedge clk); #1; check(conv == 1'b0, "R9 single cycle", conv, 0);
    repeat (20) @(negedge clk);
    hw = 1'b0;
    close_frame();
    check(conv_cnt == c0 + 1, "R9 pending consumed", conv_cnt - c0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame_rise();
    t_main_sw_pending();
    t_sw_idle();
    t_hw_busy();
    t_zero_delay();
    t_partial_frame();
    t_restart();
    t_coincide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule